// File: doc/BRIEF.md
# Flash Sector ECC Engine

This block protects one flash sector while its 16-bit words stream between a buffer memory and a flash page buffer. A sector is 256 main words followed by 8 spare words. Two independent codes are kept for each sector. A 24-bit row/column parity code covers the main data. A 10-bit code of the same kind covers only spare words 1 and 2.

In program direction the block computes both codes on the fly and writes them into fixed spare words as they pass. In load direction it passes every word through unchanged, including the stored codes. It recomputes both codes and forms the syndrome against the stored ones. When the sector ends it reports a status for each area. For a single data-bit error it also places the failing word and bit in result registers and pulses a fix strobe. The buffer then applies that flip as a read-modify-write.

A bypass bit turns off all code work. Program data then passes untouched. A load marks both status fields invalid. Direction and bypass are taken from the pins on word 0 of each sector and held until the sector ends. A boot-time load uses the same load path.

Top module: `secc_engine`

## Requirements
- R1: Words are numbered 0..263 within a sector, counted on accepted input words from reset; 0..255 are main data and 256..263 are spare words 0..7. Every accepted word appears on the output one cycle later, with its number on `out_idx`.
- R2: In program with bypass off, output word 259 carries main code bits [15:0] and the low 8 bits of word 260 carry main code bits [23:16]. The low 10 bits of word 261 carry the spare code. All other bits and words pass unchanged.
- R3: Main code: each data bit has the 12-bit address {word[7:0], bit[3:0]}. Code bit k (k<12) is the XOR of the data bits whose address bit k is 1. Code bit 12+k is the XOR of those whose address bit k is 0.
- R4: Spare code: over words 257 and 258 only, with the 5-bit address {word is 258, bit[3:0]}. Code bit k (k<5) is the XOR where address bit k is 1, and code bit 5+k the XOR where it is 0.
- R5: In load, every word including the stored code words leaves unchanged.
- R6: In load, the main syndrome is the stored code XOR the recomputed code, and `main_status` is set from it (00 clean, 01 corrected, 10 uncorrectable, 11 invalid). A zero syndrome gives 00. Low 12 bits equal to the inverse of the high 12 bits gives 01: `res_main_word`/`res_main_bit` take the low bits and `fix_main` pulses. A single set bit gives 01 with no fix. Any other syndrome gives 10 with no fix.
- R7: `sec_done` pulses for exactly one cycle, in the cycle in which word 263 is on the output. Status, result and fix outputs change only in that cycle.
- R8: The spare area is judged on its own by the same rule into `spare_status`. A correctable error sets `res_spare_word` (0 = word 257, 1 = word 258) and `res_spare_bit` and pulses `fix_spare`.
- R9: With bypass on, a program sector passes every word unchanged.
- R10: With bypass on, a load sets both status fields to 11, gives no fix pulse and leaves the result registers unchanged.
- R11: Direction and bypass are sampled on word 0; changes later in the sector have no effect.
- R12: A program sector pulses `sec_done` but leaves both status fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bypass | input | 1 | 1 = no code generation or checking |
| cfg_load | input | 1 | 1 = load direction, 0 = program direction |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 16 | Output word |
| out_idx | output | 9 | Number of the output word within the sector |
| sec_done | output | 1 | Last word of a sector is on the output |
| main_status | output | 2 | Main area status |
| spare_status | output | 2 | Spare area status |
| res_main_word | output | 8 | Failing main word |
| res_main_bit | output | 4 | Failing main bit |
| res_spare_word | output | 1 | Failing protected spare word (0 = 257, 1 = 258) |
| res_spare_bit | output | 4 | Failing spare bit |
| fix_main | output | 1 | Flip request for the main result position |
| fix_spare | output | 1 | Flip request for the spare result position |

## Verification
The hardest cases to reach are the syndrome classes other than clean and single data error. These are an error lying in a stored code bit, two errors whose syndrome could look correctable, and faults in the two corner positions of the address space. The bench first programs a random sector so that it holds valid stored codes. It then replays that image in load direction with chosen bits flipped: in main data, in spare words 257/258 and in the code words themselves. Lone set bits on otherwise empty sectors pin down every code bit position directly.

// File: rtl/secc_pkg.sv
// Package: shared constants and enumerations of the flash sector ECC engine.
// Assumes 16-bit data words; sector geometry is a parameter of the top.
package secc_pkg;
    localparam int DW     = 16;
    localparam int BIT_AW = 4;

    // Status field values reported per area
    typedef enum logic [1:0] {
        ST_CLEAN   = 2'b00,
        ST_FIXED   = 2'b01,
        ST_UNCORR  = 2'b10,
        ST_INVALID = 2'b11
    } secc_status_e;

    // Syndrome classes
    typedef enum logic [1:0] {
        SYN_NONE  = 2'b00,
        SYN_DATA  = 2'b01,
        SYN_CODE  = 2'b10,
        SYN_MULTI = 2'b11
    } secc_syn_e;
endpackage

// File: rtl/secc_parity_acc.sv
// Module: row/column parity accumulator. One word per enabled cycle; each
// data bit has address {word_idx, bit position}. Code layout: [AW-1:0]
// parities over bits whose address bit is 1, [2AW-1:AW] over bits where 0.
// Assumes clr coincides with the first word of an area (or with no word).
module secc_parity_acc
    import secc_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [WORD_AW-1:0]   word_idx,
    input  logic [DW-1:0]        data,
    output logic [2*(BIT_AW+WORD_AW)-1:0] code
);
    localparam int AW = BIT_AW + WORD_AW;
    localparam int CW = 2 * AW;

    // Lanes whose bit position has address bit k set
    function automatic logic [DW-1:0] lane_mask(input int k);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = 1'((i >> k) & 1);
        return m;
    endfunction

    logic [CW-1:0] contrib;
    logic          wpar;

    // Contribution of the current word to every parity bit
    always_comb begin
        wpar = ^data;
        for (int k = 0; k < BIT_AW; k++) begin
            contrib[k]      = ^(data & lane_mask(k));
            contrib[AW + k] = ^(data & ~lane_mask(k));
        end
        for (int j = 0; j < WORD_AW; j++) begin
            contrib[BIT_AW + j]      = wpar & word_idx[j];
            contrib[AW + BIT_AW + j] = wpar & ~word_idx[j];
        end
    end

    // Accumulate, restarting from zero on clr
    always_ff @(posedge clk) begin
        if (!rst_n)      code <= '0;
        else if (en)     code <= (clr ? '0 : code) ^ contrib;
        else if (clr)    code <= '0;
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !en) |=> (code == '0)); // R3
endmodule

// File: rtl/secc_syndrome.sv
// Module: syndrome classifier. Compares a stored and a recomputed code of
// the row/column layout and names the error class; pos is the odd half.
// Purely combinational.
module secc_syndrome
    import secc_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [2*AW-1:0] stored,
    input  logic [2*AW-1:0] calc,
    output secc_syn_e       cls,
    output logic [AW-1:0]   pos
);
    logic [2*AW-1:0] syn;

    // Classify the syndrome
    always_comb begin
        syn = stored ^ calc;
        pos = syn[AW-1:0];
        if (syn == '0)                              cls = SYN_NONE;
        else if (syn[AW-1:0] == ~syn[2*AW-1:AW])    cls = SYN_DATA;
        else if ($countones(syn) == 1)              cls = SYN_CODE;
        else                                        cls = SYN_MULTI;
    end
endmodule

// File: rtl/secc_engine.sv
// Module: flash sector ECC engine top. Streams one sector (main words then
// spare words); in program it inserts the main and spare codes, in load it
// checks them and reports status, result position and fix strobes.
// Assumes MAIN_WORDS is a power of two and the main code is 17..32 bits.
module secc_engine
    import secc_pkg::*;
#(
    parameter int MAIN_WORDS  = 256,
    parameter int SPARE_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_bypass,
    input  logic        cfg_load,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    output logic        out_valid,
    output logic [15:0] out_data,
    output logic [8:0]  out_idx,
    output logic        sec_done,
    output logic [1:0]  main_status,
    output logic [1:0]  spare_status,
    output logic [7:0]  res_main_word,
    output logic [3:0]  res_main_bit,
    output logic        res_spare_word,
    output logic [3:0]  res_spare_bit,
    output logic        fix_main,
    output logic        fix_spare
);
    localparam int SECTOR_WORDS = MAIN_WORDS + SPARE_WORDS;
    localparam int IDX_W   = $clog2(SECTOR_WORDS);
    localparam int MAIN_AW = $clog2(MAIN_WORDS);
    localparam int M_AW    = BIT_AW + MAIN_AW;
    localparam int S_AW    = BIT_AW + 1;
    localparam int M_CW    = 2 * M_AW;
    localparam int S_CW    = 2 * S_AW;
    localparam int HI_W    = M_CW - DW;
    localparam logic [IDX_W-1:0] MAIN_END = IDX_W'(MAIN_WORDS);
    localparam logic [IDX_W-1:0] IX_PROT0 = IDX_W'(MAIN_WORDS + 1);
    localparam logic [IDX_W-1:0] IX_PROT1 = IDX_W'(MAIN_WORDS + 2);
    localparam logic [IDX_W-1:0] IX_MLO   = IDX_W'(MAIN_WORDS + 3);
    localparam logic [IDX_W-1:0] IX_MHI   = IDX_W'(MAIN_WORDS + 4);
    localparam logic [IDX_W-1:0] IX_SCODE = IDX_W'(MAIN_WORDS + 5);
    localparam logic [IDX_W-1:0] IX_LAST  = IDX_W'(SECTOR_WORDS - 1);

    logic [IDX_W-1:0] cnt;
    logic             load_q, byp_q;
    logic             first, last, eff_load, eff_byp, is_main, is_prot;
    logic             end_load;
    logic [M_CW-1:0]  main_calc, main_st;
    logic [S_CW-1:0]  spr_calc, spr_st;
    logic [DW-1:0]    word_out;
    secc_syn_e        m_cls, s_cls;
    logic [M_AW-1:0]  m_pos;
    logic [S_AW-1:0]  s_pos;

    // Map a syndrome class to a status code
    function automatic logic [1:0] to_status(input secc_syn_e c);
        case (c)
            SYN_NONE:          return ST_CLEAN;
            SYN_DATA, SYN_CODE: return ST_FIXED;
            default:           return ST_UNCORR;
        endcase
    endfunction

    // Position decode and effective sector configuration
    always_comb begin
        first    = (cnt == '0);
        last     = (cnt == IX_LAST);
        eff_load = first ? cfg_load   : load_q;
        eff_byp  = first ? cfg_bypass : byp_q;
        is_main  = (cnt < MAIN_END);
        is_prot  = (cnt == IX_PROT0) || (cnt == IX_PROT1);
        end_load = in_valid && last && eff_load;
    end

    // Word counter and per-sector configuration latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            load_q <= 1'b0;
            byp_q  <= 1'b0;
        end else if (in_valid) begin
            cnt <= last ? '0 : cnt + 1'b1;
            if (first) begin
                load_q <= cfg_load;
                byp_q  <= cfg_bypass;
            end
        end
    end

    secc_parity_acc #(.WORD_AW(MAIN_AW)) u_main_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (in_valid && first),
        .en       (in_valid && is_main && !eff_byp),
        .word_idx (cnt[MAIN_AW-1:0]),
        .data     (in_data),
        .code     (main_calc)
    );

    secc_parity_acc #(.WORD_AW(1)) u_spare_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (in_valid && first),
        .en       (in_valid && is_prot && !eff_byp),
        .word_idx (cnt == IX_PROT1),
        .data     (in_data),
        .code     (spr_calc)
    );

    // Capture the stored codes as they pass in load direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_st <= '0;
            spr_st  <= '0;
        end else if (in_valid && eff_load) begin
            if (cnt == IX_MLO)   main_st[DW-1:0]    <= in_data;
            if (cnt == IX_MHI)   main_st[M_CW-1:DW] <= in_data[HI_W-1:0];
            if (cnt == IX_SCODE) spr_st             <= in_data[S_CW-1:0];
        end
    end

    secc_syndrome #(.AW(M_AW)) u_main_syn (
        .stored (main_st), .calc (main_calc), .cls (m_cls), .pos (m_pos)
    );

    secc_syndrome #(.AW(S_AW)) u_spare_syn (
        .stored (spr_st), .calc (spr_calc), .cls (s_cls), .pos (s_pos)
    );

    // Code insertion on the program path
    always_comb begin
        word_out = in_data;
        if (!eff_load && !eff_byp) begin
            if (cnt == IX_MLO)   word_out = main_calc[DW-1:0];
            if (cnt == IX_MHI)   word_out = {in_data[DW-1:HI_W], main_calc[M_CW-1:DW]};
            if (cnt == IX_SCODE) word_out = {in_data[DW-1:S_CW], spr_calc};
        end
    end

    // Output word register and end-of-sector pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_idx   <= '0;
            sec_done  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            sec_done  <= in_valid && last;
            if (in_valid) begin
                out_data <= word_out;
                out_idx  <= cnt;
            end
        end
    end

    // Status, result and fix strobes at the end of a load sector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_status    <= ST_CLEAN;
            spare_status   <= ST_CLEAN;
            res_main_word  <= '0;
            res_main_bit   <= '0;
            res_spare_word <= 1'b0;
            res_spare_bit  <= '0;
            fix_main       <= 1'b0;
            fix_spare      <= 1'b0;
        end else begin
            fix_main  <= end_load && !eff_byp && (m_cls == SYN_DATA);
            fix_spare <= end_load && !eff_byp && (s_cls == SYN_DATA);
            if (end_load) begin
                if (eff_byp) begin
                    main_status  <= ST_INVALID;
                    spare_status <= ST_INVALID;
                end else begin
                    main_status  <= to_status(m_cls);
                    spare_status <= to_status(s_cls);
                    if (m_cls == SYN_DATA) begin
                        res_main_word <= m_pos[M_AW-1:BIT_AW];
                        res_main_bit  <= m_pos[BIT_AW-1:0];
                    end
                    if (s_cls == SYN_DATA) begin
                        res_spare_word <= s_pos[BIT_AW];
                        res_spare_bit  <= s_pos[BIT_AW-1:0];
                    end
                end
            end
        end
    end

    AST_OUT_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        sec_done |-> (out_valid && out_idx == IX_LAST)); // R7
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_done |-> ($stable(main_status) && $stable(spare_status))); // R7
    AST_FIX_MAIN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        fix_main |-> (sec_done && main_status == ST_FIXED)); // R6
    AST_FIX_SPARE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        fix_spare |-> (sec_done && spare_status == ST_FIXED)); // R8
    AST_BYPASS_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_done && main_status == ST_INVALID) |-> (!fix_main && !fix_spare)); // R10
endmodule

// File: tb/secc_engine_tb.sv
`timescale 1ns/1ps
module secc_engine_tb;
    localparam int NW = 264;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bypass = 1'b0, cfg_load = 1'b0, in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid, sec_done, res_spare_word, fix_main, fix_spare;
    logic [15:0] out_data;
    logic [8:0]  out_idx;
    logic [1:0]  main_status, spare_status;
    logic [7:0]  res_main_word;
    logic [3:0]  res_main_bit, res_spare_bit;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    secc_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_load(cfg_load),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .out_idx(out_idx), .sec_done(sec_done),
        .main_status(main_status), .spare_status(spare_status),
        .res_main_word(res_main_word), .res_main_bit(res_main_bit),
        .res_spare_word(res_spare_word), .res_spare_bit(res_spare_bit),
        .fix_main(fix_main), .fix_spare(fix_spare)
    );

    logic [15:0] ref_img [NW];
    logic [15:0] exp_img [NW];
    logic [15:0] got     [NW];
    int done_cnt, done_at_last, fixm_cnt, fixs_cnt;
    logic [1:0] cap_ms, cap_ss;

    // Monitor: sample outputs mid-cycle
    always @(negedge clk) begin
        if (out_valid) got[out_idx] = out_data;
        if (sec_done) begin
            done_cnt++;
            if (out_valid && out_idx == 9'd263) done_at_last++;
            cap_ms = main_status;
            cap_ss = spare_status;
        end
        if (fix_main)  fixm_cnt++;
        if (fix_spare) fixs_cnt++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model_main();
        logic [23:0] c = '0;
        for (int w = 0; w < 256; w++)
            for (int b = 0; b < 16; b++)
                if (ref_img[w][b]) begin
                    logic [11:0] a = {w[7:0], b[3:0]};
                    for (int k = 0; k < 12; k++)
                        if (a[k]) c[k] ^= 1'b1; else c[12+k] ^= 1'b1;
                end
        return c;
    endfunction

    function automatic logic [9:0] model_spare();
        logic [9:0] c = '0;
        for (int w = 257; w <= 258; w++)
            for (int b = 0; b < 16; b++)
                if (ref_img[w][b]) begin
                    logic [4:0] a = {w == 258, b[3:0]};
                    for (int k = 0; k < 5; k++)
                        if (a[k]) c[k] ^= 1'b1; else c[5+k] ^= 1'b1;
                end
        return c;
    endfunction

    // Expected program output from ref_img (bypass off)
    task automatic build_expected();
        logic [23:0] m = model_main();
        logic [9:0]  s = model_spare();
        for (int i = 0; i < NW; i++) exp_img[i] = ref_img[i];
        exp_img[259]      = m[15:0];
        exp_img[260][7:0] = m[23:16];
        exp_img[261][9:0] = s;
    endtask

    // Drive one sector of src words; toggle flips the config after word 0
    task automatic drive(input logic [15:0] src [NW], input bit load, input bit byp, input bit toggle);
        done_cnt = 0; done_at_last = 0; fixm_cnt = 0; fixs_cnt = 0;
        for (int i = 0; i < NW; i++) got[i] = 16'hxxxx;
        for (int i = 0; i < NW; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                @(negedge clk); in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid   = 1'b1;
            in_data    = src[i];
            cfg_load   = (toggle && i > 0) ? ~load : load;
            cfg_bypass = (toggle && i > 0) ? ~byp  : byp;
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int mism(input logic [15:0] e [NW]);
        int n = 0;
        for (int i = 0; i < NW; i++) if (got[i] !== e[i]) n++;
        return n;
    endfunction

    // Load src and compare all outputs with the expected results
    task automatic load_check(input string tag, input logic [15:0] src [NW],
                              input logic [1:0] ems, input logic [1:0] ess,
                              input int efm, input int efs,
                              input logic [7:0] ew, input logic [3:0] eb,
                              input logic esw, input logic [3:0] esb);
        drive(src, 1'b1, 1'b0, 1'b0);
        check(mism(src) == 0, {tag, " R5 passthrough"}, mism(src), 0);
        check(done_cnt == 1 && done_at_last == 1, {tag, " R7 done"}, done_cnt, 1);
        check(cap_ms == ems, {tag, " R6 main_status"}, cap_ms, ems);
        check(cap_ss == ess, {tag, " R8 spare_status"}, cap_ss, ess);
        check(fixm_cnt == efm, {tag, " R6 fix_main"}, fixm_cnt, efm);
        check(fixs_cnt == efs, {tag, " R8 fix_spare"}, fixs_cnt, efs);
        if (efm == 1) check({res_main_word, res_main_bit} == {ew, eb}, {tag, " R6 result"},
                            {res_main_word, res_main_bit}, {ew, eb});
        if (efs == 1) check({res_spare_word, res_spare_bit} == {esw, esb}, {tag, " R8 result"},
                            {res_spare_word, res_spare_bit}, {esw, esb});
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [15:0] img [NW];
    logic [15:0] cln [NW];
    logic [1:0]  pms, pss;
    logic [11:0] pres;

    initial begin
        void'($urandom(32'h5EC7_0A11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !sec_done && !fix_main && !fix_spare, "R1 reset outputs", out_valid, 0);
        check(main_status == 2'b00 && spare_status == 2'b00, "R6 reset status", {main_status, spare_status}, 0);

        // R3: lone bit at word 5 bit 3 gives code {~A, A}
        for (int i = 0; i < NW; i++) ref_img[i] = 16'h0;
        ref_img[5][3] = 1'b1;
        drive(ref_img, 1'b0, 1'b0, 1'b0);
        check({got[260][7:0], got[259]} == {~12'h053, 12'h053}, "R3 lone bit main code",
              {got[260][7:0], got[259]}, {~12'h053, 12'h053});
        // R4: lone bit at spare word 258 bit 7 gives code {~A, A}
        for (int i = 0; i < NW; i++) ref_img[i] = 16'h0;
        ref_img[258][7] = 1'b1;
        drive(ref_img, 1'b0, 1'b0, 1'b0);
        check(got[261][9:0] == {~5'h17, 5'h17}, "R4 lone bit spare code", got[261][9:0], {~5'h17, 5'h17});

        // Random program sectors, checked against the model
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < NW; i++) ref_img[i] = 16'($urandom);
            build_expected();
            pms = main_status; pss = spare_status;
            drive(ref_img, 1'b0, 1'b0, 1'b0);
            check(mism(exp_img) == 0, "R2 program insertion", mism(exp_img), 0);
            check(done_cnt == 1 && done_at_last == 1, "R7 program done", done_cnt, 1);
            check(main_status == pms && spare_status == pss, "R12 program keeps status",
                  {main_status, spare_status}, {pms, pss});
        end

        // R11: config toggled after word 0 is ignored
        drive(ref_img, 1'b0, 1'b0, 1'b1);
        check(mism(exp_img) == 0, "R11 mid-sector config ignored", mism(exp_img), 0);

        // R9: bypass program passes everything
        drive(ref_img, 1'b0, 1'b1, 1'b0);
        check(mism(ref_img) == 0, "R9 bypass program unchanged", mism(ref_img), 0);

        cln = exp_img;
        load_check("clean", cln, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
        img = cln; img[0][0] ^= 1'b1;
        load_check("corner w0b0", img, 2'b01, 2'b00, 1, 0, 8'd0, 4'd0, 0, 0);
        img = cln; img[255][15] ^= 1'b1;
        load_check("corner w255b15", img, 2'b01, 2'b00, 1, 0, 8'd255, 4'd15, 0, 0);
        img = cln; img[10][1] ^= 1'b1; img[200][9] ^= 1'b1;
        load_check("double main", img, 2'b10, 2'b00, 0, 0, 0, 0, 0, 0);
        img = cln; img[77][2] ^= 1'b1; img[77][13] ^= 1'b1;
        load_check("double same word", img, 2'b10, 2'b00, 0, 0, 0, 0, 0, 0);
        img = cln; img[259][4] ^= 1'b1;
        load_check("stored code bit", img, 2'b01, 2'b00, 0, 0, 0, 0, 0, 0);
        img = cln; img[257][6] ^= 1'b1;
        load_check("spare w257", img, 2'b00, 2'b01, 0, 1, 0, 0, 1'b0, 4'd6);
        img = cln; img[258][15] ^= 1'b1;
        load_check("spare w258", img, 2'b00, 2'b01, 0, 1, 0, 0, 1'b1, 4'd15);
        img = cln; img[257][0] ^= 1'b1; img[258][0] ^= 1'b1;
        load_check("spare double", img, 2'b00, 2'b10, 0, 0, 0, 0, 0, 0);

        // Random single errors in both areas
        for (int r = 0; r < 8; r++) begin
            int w = $urandom_range(0, 255);
            int b = $urandom_range(0, 15);
            int sw = $urandom_range(257, 258);
            int sb = $urandom_range(0, 15);
            img = cln; img[w][b] ^= 1'b1; img[sw][sb] ^= 1'b1;
            load_check("random single", img, 2'b01, 2'b01, 1, 1, w[7:0], b[3:0], sw == 258, sb[3:0]);
        end

        // R10: bypass load with an error
        pres = {res_main_word, res_main_bit};
        img = cln; img[3][3] ^= 1'b1;
        drive(img, 1'b1, 1'b1, 1'b0);
        check(cap_ms == 2'b11 && cap_ss == 2'b11, "R10 bypass status invalid", {cap_ms, cap_ss}, 4'hF);
        check(fixm_cnt == 0 && fixs_cnt == 0, "R10 bypass no fix", fixm_cnt + fixs_cnt, 0);
        check({res_main_word, res_main_bit} == pres, "R10 bypass result held",
              {res_main_word, res_main_bit}, pres);

        finish_run();
    end
endmodule